// File: doc/BRIEF.md
# Half-Step Clock Divider with Duty Modes

This block derives a slower clock from a source clock. The ratio can be an integer or a half-step value, and a mode bit selects the duty-cycle policy. In low-frequency mode every ratio gives an exact 50/50 output. In high-frequency mode integer ratios stay at 50/50, but a half-step ratio N+0.5 gives a high phase that is one source half-period shorter than its low phase.

A half-step ratio needs output edges on both edges of the source clock, and sometimes between them. For that reason the block runs from a reference clock at twice the source rate that is phase-aligned to it, and it works on both edges of that reference. The ratio is given as a code equal to twice the ratio. The code and the mode bit are captured only while reset is held. The host holds reset, sets code and mode, and releases reset. The divided clock then starts with a rising edge at the next reference rising edge.

The rising-edge side is a three-state sequencer. Its states are:
- `ST_ARM`: the next rising edge starts a period, and the output rises.
- `ST_HIGH`: the output is high, and the sequencer waits for the fall slot.
- `ST_LOW`: the output is low until the last slot of the period.

Its transitions are:
- `ST_ARM` → `ST_HIGH` on every rising edge.
- `ST_HIGH` → `ST_LOW` at the fall slot. The sequencer either drops the output directly, or asks the falling-edge register to drop it half a reference cycle later.
- `ST_LOW` → `ST_ARM` at the last slot.

Reset enters `ST_ARM` at slot 0.

Top module: `hdiv_top`

## Requirements
- R1: One output period lasts exactly `code` reference clock periods. This equals the ratio times the source period, where the ratio is code/2.
- R2: The code is 6 bits wide and equals twice the ratio. The legal codes are every value from 3 to 15, and every even value from 16 to 32.
- R3: Any code outside the legal set makes the block divide with code 4, which is a ratio of 2.
- R4: When `hf_mode_i` is 0, the output is high for exactly `code` reference half-periods, which is half the period, for every legal code.
- R5: When `hf_mode_i` is 1 and the code is even, the output is high for exactly half the period.
- R6: When `hf_mode_i` is 1 and the code is odd (2N+1), the output is high for 2N reference half-periods and low for 2N+2 reference half-periods. This gives a duty of N/(2N+1).
- R7: While `rst_i` is 1, `clk_div_o` is 0. Reset acts asynchronously.
- R8: The first rising edge of `clk_div_o` comes at the first rising edge of `clk2x_i` after reset is released. Every later rising edge also falls on a rising edge of `clk2x_i`.
- R9: The code and the mode are captured at rising edges of `clk2x_i` while `rst_i` is 1. Changes while running have no effect until the next reset.
- R10: Each output edge is produced by a register toggle on one reference edge. A falling edge lands on a falling edge of `clk2x_i` only when `hf_mode_i` is 0 and the code is odd; every other falling edge lands on a rising edge of `clk2x_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x_i | input | 1 | Reference clock at twice the source rate, phase-aligned to it |
| rst_i | input | 1 | Active-high reset; code and mode are captured while it is high |
| div_code_i | input | 6 | Twice the divide ratio |
| hf_mode_i | input | 1 | 1 = high-frequency duty policy, 0 = low-frequency policy |
| clk_div_o | output | 1 | Divided clock |

## Verification
All results are due at fixed offsets from the release of reset:
- Reset is released on a reference falling edge, so the first rise is due one reference half-period (4 ns) later.
- The fall is due 2N or 2N+1 half-periods after the rise, depending on mode and code.
- The next rise is due `code` full reference periods after the first.

The bench records the simulation time of each output edge as it happens and compares differences and edge phases against these offsets. It therefore never samples at a guessed cycle. The ignored-change check alters the code and the mode after the first period, then measures the following period at the same offsets.

// File: rtl/hdiv_pkg.sv
`timescale 1ns/1ps
package hdiv_pkg;

    // Width of the divide code (twice the ratio).
    parameter int unsigned HD_CODE_W = 6;

    // Sequencer states of the rising-edge side.
    typedef enum logic [1:0] {
        ST_ARM  = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } hdiv_state_e;

    // Configuration frozen at reset, expressed in rising-edge slots.
    typedef struct packed {
        logic [HD_CODE_W-1:0] last_slot;  // code - 1
        logic [HD_CODE_W-1:0] fall_slot;  // slot whose edge (or the half after it) drops the output
        logic                 fall_late;  // drop at the following falling edge
    } hdiv_cfg_t;

endpackage

// File: rtl/hdiv_cfg_capture.sv
`timescale 1ns/1ps
module hdiv_cfg_capture
    import hdiv_pkg::*;
#(
    parameter int unsigned CODE_MIN = 3,
    parameter int unsigned CODE_MAX = 32,
    parameter int unsigned ODD_MAX  = 15,
    parameter int unsigned CODE_DEF = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [HD_CODE_W-1:0] code_i,
    input  logic                 hf_i,
    output hdiv_cfg_t            cfg_o
);

    localparam logic [HD_CODE_W-1:0] C_MIN = HD_CODE_W'(CODE_MIN);
    localparam logic [HD_CODE_W-1:0] C_MAX = HD_CODE_W'(CODE_MAX);
    localparam logic [HD_CODE_W-1:0] C_ODD = HD_CODE_W'(ODD_MAX);
    localparam logic [HD_CODE_W-1:0] C_DEF = HD_CODE_W'(CODE_DEF);

    logic                 in_range;
    logic                 step_ok;
    logic [HD_CODE_W-1:0] eff_code;
    logic [HD_CODE_W-1:0] high_span;
    hdiv_cfg_t            cfg_d;
    hdiv_cfg_t            cfg_q;

    // Legal set: full range up to ODD_MAX, even codes above it.
    always_comb begin
        in_range = (code_i >= C_MIN) && (code_i <= C_MAX);
        step_ok  = (code_i <= C_ODD) || !code_i[0];
        eff_code = (in_range && step_ok) ? code_i : C_DEF;
    end

    // High span in reference half-periods: one less for odd codes in hf mode.
    always_comb begin
        if (hf_i && eff_code[0]) begin
            high_span = eff_code - HD_CODE_W'(1);
        end else begin
            high_span = eff_code;
        end
        cfg_d.last_slot = eff_code - HD_CODE_W'(1);
        cfg_d.fall_slot = high_span >> 1;
        cfg_d.fall_late = high_span[0];
    end

    // Loaded only while reset is held; frozen while running.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/hdiv_phase_fsm.sv
`timescale 1ns/1ps
module hdiv_phase_fsm
    import hdiv_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  hdiv_cfg_t            cfg_i,
    output logic                 tog_o,
    output logic                 late_o,
    output hdiv_state_e          state_o,
    output logic [HD_CODE_W-1:0] slot_o
);

    hdiv_state_e          state_q, state_d;
    logic [HD_CODE_W-1:0] slot_q, slot_d;
    logic                 flip_now;
    logic                 late_d;
    logic                 tog_q;
    logic                 late_q;

    // Next-state and action decode.
    always_comb begin
        state_d  = state_q;
        slot_d   = slot_q + HD_CODE_W'(1);
        flip_now = 1'b0;
        late_d   = 1'b0;
        unique case (state_q)
            ST_ARM: begin
                flip_now = 1'b1;
                state_d  = ST_HIGH;
            end
            ST_HIGH: begin
                if (slot_q == cfg_i.fall_slot) begin
                    state_d = ST_LOW;
                    if (cfg_i.fall_late) begin
                        late_d = 1'b1;
                    end else begin
                        flip_now = 1'b1;
                    end
                end
            end
            ST_LOW: begin
                if (slot_q == cfg_i.last_slot) begin
                    state_d = ST_ARM;
                    slot_d  = '0;
                end
            end
            default: begin
                state_d = ST_ARM;
                slot_d  = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            state_q <= ST_ARM;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    // Output registers.
    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            tog_q  <= 1'b0;
            late_q <= 1'b0;
        end else begin
            tog_q  <= tog_q ^ flip_now;
            late_q <= late_d;
        end
    end

    assign tog_o   = tog_q;
    assign late_o  = late_q;
    assign state_o = state_q;
    assign slot_o  = slot_q;

endmodule

// File: rtl/hdiv_late_edge.sv
`timescale 1ns/1ps
module hdiv_late_edge (
    input  logic clk_i,
    input  logic rst_i,
    input  logic late_i,
    output logic tog_o
);

    logic tog_q;

    // Falling-edge toggle: carries the mid-cycle fall of odd low-frequency codes.
    always_ff @(negedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            tog_q <= 1'b0;
        end else if (late_i) begin
            tog_q <= ~tog_q;
        end
    end

    assign tog_o = tog_q;

endmodule

// File: rtl/hdiv_top.sv
`timescale 1ns/1ps
module hdiv_top
    import hdiv_pkg::*;
#(
    parameter int unsigned CODE_MIN = 3,
    parameter int unsigned CODE_MAX = 32,
    parameter int unsigned ODD_MAX  = 15,
    parameter int unsigned CODE_DEF = 4
) (
    input  logic                 clk2x_i,
    input  logic                 rst_i,
    input  logic [HD_CODE_W-1:0] div_code_i,
    input  logic                 hf_mode_i,
    output logic                 clk_div_o
);

    hdiv_cfg_t            cfg;
    hdiv_state_e          fsm_state;
    logic [HD_CODE_W-1:0] fsm_slot;
    logic                 rise_tog;
    logic                 late_req;
    logic                 fall_tog;

    hdiv_cfg_capture #(
        .CODE_MIN (CODE_MIN),
        .CODE_MAX (CODE_MAX),
        .ODD_MAX  (ODD_MAX),
        .CODE_DEF (CODE_DEF)
    ) u_cfg (
        .clk_i  (clk2x_i),
        .rst_i  (rst_i),
        .code_i (div_code_i),
        .hf_i   (hf_mode_i),
        .cfg_o  (cfg)
    );

    hdiv_phase_fsm u_fsm (
        .clk_i   (clk2x_i),
        .rst_i   (rst_i),
        .cfg_i   (cfg),
        .tog_o   (rise_tog),
        .late_o  (late_req),
        .state_o (fsm_state),
        .slot_o  (fsm_slot)
    );

    hdiv_late_edge u_late (
        .clk_i  (clk2x_i),
        .rst_i  (rst_i),
        .late_i (late_req),
        .tog_o  (fall_tog)
    );

    // Two toggle registers, never flipping on the same edge: glitch-free level.
    assign clk_div_o = rise_tog ^ fall_tog;

endmodule

// File: rtl/hdiv_checker.sv
`timescale 1ns/1ps
module hdiv_checker
    import hdiv_pkg::*;
(
    input logic                 clk_i,
    input logic                 rst_i,
    input logic                 clk_div_i,
    input hdiv_state_e          state_i,
    input logic [HD_CODE_W-1:0] slot_i,
    input logic                 late_i,
    input hdiv_cfg_t            cfg_i
);

    logic run_q;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            run_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
        end
    end

    AST_RESET_LOW: assert property (@(posedge clk_i) rst_i |-> !clk_div_i); // R7

    AST_HIGH_AFTER_ARM: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_ARM) |=> clk_div_i); // R8

    AST_SLOT_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        slot_i <= cfg_i.last_slot); // R1

    AST_LATE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        late_i |=> !late_i); // R10

    AST_LATE_FROM_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
        late_i |-> (state_i == ST_LOW) && cfg_i.fall_late); // R10

    AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        run_q |-> $stable(cfg_i)); // R9

    AST_LEGAL_SPAN: assert property (@(posedge clk_i) disable iff (rst_i)
        run_q |-> (cfg_i.last_slot >= HD_CODE_W'(2)) && (cfg_i.last_slot <= HD_CODE_W'(31))
                  && (cfg_i.last_slot <= HD_CODE_W'(14) || cfg_i.last_slot[0])); // R2

endmodule

bind hdiv_top hdiv_checker u_chk (
    .clk_i     (clk2x_i),
    .rst_i     (rst_i),
    .clk_div_i (clk_div_o),
    .state_i   (fsm_state),
    .slot_i    (fsm_slot),
    .late_i    (late_req),
    .cfg_i     (cfg)
);

// File: tb/sim_hdiv_top.sv
`timescale 1ns/1ps
module sim_hdiv_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] code = 6'd4;
    logic       hf = 1'b0;
    logic       clk_div;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;  // 125 MHz reference

    hdiv_top u0 (
        .clk2x_i    (clk),
        .rst_i      (rst),
        .div_code_i (code),
        .hf_mode_i  (hf),
        .clk_div_o  (clk_div)
    );

    function automatic bit is_legal(int c);
        return (c >= 3 && c <= 15) || (c >= 16 && c <= 32 && (c % 2) == 0);
    endfunction

    function automatic int eff_code(int c);
        return is_legal(c) ? c : 4;
    endfunction

    function automatic int high_halves(int c, bit m);
        int e = eff_code(c);
        return (m && (e % 2) == 1) ? e - 1 : e;
    endfunction

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic run_case(input int c, input bit m, input bit mid_change, input string ptag);
        longint t_rel, t_r0, t_f0, t_r1, t_f1, t_r2;
        int     e_per, e_hi;
        string  htag;
        e_per = eff_code(c) * 8;
        e_hi  = high_halves(c, m) * 4;
        htag  = !m ? "R4" : ((eff_code(c) % 2) == 0 ? "R5" : "R6");
        rst  = 1'b1;
        code = 6'(c);
        hf   = m;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7", "output during reset", longint'(clk_div), 0);
        rst   = 1'b0;
        t_rel = $time;
        @(posedge clk_div); t_r0 = $time;
        chk("R8", "first rise delay", t_r0 - t_rel, 4);
        @(negedge clk_div); t_f0 = $time;
        @(posedge clk_div); t_r1 = $time;
        chk(htag, "high time", t_f0 - t_r0, e_hi);
        chk(ptag, "period", t_r1 - t_r0, e_per);
        chk("R10", "fall phase", t_f0 % 8, (!m && (eff_code(c) % 2) == 1) ? 0 : 4);
        chk("R8", "rise phase", t_r1 % 8, 4);
        if (mid_change) begin
            code = 6'($urandom % 64);
            hf   = ~m;
            @(negedge clk_div); t_f1 = $time;
            @(posedge clk_div); t_r2 = $time;
            chk("R9", "high after change", t_f1 - t_r1, e_hi);
            chk("R9", "period after change", t_r2 - t_r1, e_per);
        end
    endtask

    initial begin
        void'($urandom(32'd7321));
        // Directed sweep over every code, both modes, legal and illegal.
        for (int c = 0; c <= 40; c++) begin
            for (int m = 0; m < 2; m++) begin
                run_case(c, m[0], 1'b0, is_legal(c) ? "R2" : "R3");
            end
        end
        // Corner codes at the top of the 6-bit range.
        run_case(63, 1'b0, 1'b0, "R3");
        run_case(33, 1'b1, 1'b0, "R3");
        // Random cases with a change while running.
        for (int i = 0; i < 40; i++) begin
            int c = int'($urandom % 64);
            run_case(c, 1'($urandom % 2), 1'b1, is_legal(c) ? "R1" : "R3");
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (R1) actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule